// File: doc/BRIEF.md
# Scannable Parallel-Load Shift Register

This block is a register of parameterised width (eight bits by default). On each rising clock edge it does one of three things: it captures a parallel word, keeps its contents, or shifts one place toward the top bit while taking a new bit at the bottom from a serial input. The shift control wins over the combined hold/load control. A single line therefore switches between hold and load, and a single line moves the register into scan mode, with no extra gating.

The top bit is also driven on a separate serial output. Several copies can be chained into one scan path by wiring each serial output to the next copy's serial input. An active-low asynchronous master clear forces every bit to zero at once. The clear wins over every clocked operation for as long as it is held.

Top module: `scan_reg`

## Requirements
- R1: Driving rst_ni low clears every bit of q_o to 0 at once, without waiting for a clock edge.
- R2: While rst_ni stays low, q_o stays 0 across clock edges, whatever the data and control inputs are.
- R3: With shift_i high, each rising edge moves bit n to bit n+1 and loads ser_i into bit 0.
- R4: With shift_i high, the level of hold_i, including changes to it between edges, has no effect on the result of a shift.
- R5: With shift_i low and hold_i low, a rising edge copies par_i into q_o.
- R6: With shift_i low and hold_i high, q_o keeps its value across rising edges.
- R7: ser_o always equals the top bit, q_o[WIDTH-1].
- R8: After WIDTH consecutive shifts of a serial pattern, q_o holds exactly that pattern, and the first bit shifted in is at q_o[WIDTH-1].
- R9: After rst_ni is released between edges, the first rising edge performs the operation that the controls select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous master clear |
| par_i | input | WIDTH | Parallel data word |
| ser_i | input | 1 | Serial data into bit 0 |
| shift_i | input | 1 | Shift select; overrides hold_i |
| hold_i | input | 1 | High keeps contents, low loads par_i |
| q_o | output | WIDTH | Register contents |
| ser_o | output | 1 | Top bit, for chaining a scan path |

## Verification
On every edge outside reset, the embedded properties check the next-state rule for each mode: shift (regardless of hold_i), load and hold. They also check that q_o is zero on every edge where the clear is held. Only the directed scenarios can show the following: a clear asserted between edges empties the outputs before the next edge; a full pattern shifted in arrives in the expected bit order; and operation restarts on the first edge after release. The serial output's agreement with the top bit is observed by the bench at the ports.

// File: rtl/scan_reg_pkg.sv
package scan_reg_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_HOLD  = 2'd1,
    OP_SHIFT = 2'd2
  } op_e;
endpackage

// File: rtl/scan_reg_ctrl.sv
module scan_reg_ctrl
  import scan_reg_pkg::*;
(
  input  logic shift_i,
  input  logic hold_i,
  output op_e  op_o
);
  // shift wins over hold/load
  always_comb begin
    if (shift_i)     op_o = OP_SHIFT;
    else if (hold_i) op_o = OP_HOLD;
    else             op_o = OP_LOAD;
  end
endmodule

// File: rtl/scan_reg_cell.sv
module scan_reg_cell
  import scan_reg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic par_i,
  input  logic shin_i,
  output logic q_o
);
  logic d;

  always_comb begin
    unique case (op_i)
      OP_SHIFT: d = shin_i;
      OP_LOAD:  d = par_i;
      default:  d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/scan_reg.sv
module scan_reg
  import scan_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  input  logic             shift_i,
  input  logic             hold_i,
  output logic [WIDTH-1:0] q_o,
  output logic             ser_o
);
  localparam int TOP = WIDTH - 1;

  op_e              op;
  logic [WIDTH-1:0] shin;

  scan_reg_ctrl u_ctrl (
    .shift_i (shift_i),
    .hold_i  (hold_i),
    .op_o    (op)
  );

  // each cell takes its lower neighbour in shift mode
  assign shin = {q_o[TOP-1:0], ser_i};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    scan_reg_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op),
      .par_i  (par_i[i]),
      .shin_i (shin[i]),
      .q_o    (q_o[i])
    );
  end

  assign ser_o = q_o[TOP];

  // R3 R4
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> q_o == {$past(q_o[TOP-1:0]), $past(ser_i)});

  // R5
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !hold_i) |=> q_o == $past(par_i));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && hold_i) |=> $stable(q_o));

  // R2
  clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);
endmodule

// File: tb/scan_reg_bench.sv
module scan_reg_bench;
  localparam int W = 8;
  localparam int PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] par_i = '0;
  logic         ser_i = 1'b0;
  logic         shift_i = 1'b0;
  logic         hold_i = 1'b1;
  logic [W-1:0] q_o;
  logic         ser_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  scan_reg #(.WIDTH(W)) u_scan_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .par_i (par_i), .ser_i (ser_i),
    .shift_i (shift_i), .hold_i (hold_i), .q_o (q_o), .ser_o (ser_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one rising edge, then settle away from it
  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    #1 rst_ni = 1'b0;
    #1;
    check("R1", q_o, '0);
    repeat (2) step();
    rst_ni = 1'b1;
    check("R2", q_o, '0);
  endtask

  task automatic t_load();
    logic [W-1:0] pats [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h01};
    shift_i = 1'b0;
    hold_i = 1'b0;
    foreach (pats[k]) begin
      par_i = pats[k];
      step();
      check("R5", q_o, pats[k]);
      check("R7", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, pats[k][W-1]});
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] keep = q_o;
    hold_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      par_i = ~keep ^ W'(k);
      ser_i = ~ser_i;
      step();
      check("R6", q_o, keep);
    end
  endtask

  task automatic t_shift();
    logic [W-1:0] exp;
    shift_i = 1'b0; hold_i = 1'b0; par_i = 8'h96;
    step();
    exp = 8'h96;
    shift_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      ser_i = k[0];
      step();
      exp = {exp[W-2:0], k[0]};
      check("R3", q_o, exp);
    end
  endtask

  task automatic t_pattern(input logic [W-1:0] pat);
    shift_i = 1'b1;
    for (int k = W-1; k >= 0; k--) begin
      ser_i = pat[k];
      step();
    end
    check("R8", q_o, pat);
    check("R7", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, pat[W-1]});
  endtask

  task automatic t_shift_ignores_hold();
    logic [W-1:0] exp = q_o;
    shift_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      hold_i = k[0];
      par_i = 8'h5A;
      ser_i = k[1];
      #2 hold_i = ~hold_i;
      step();
      exp = {exp[W-2:0], k[1]};
      check("R4", q_o, exp);
    end
  endtask

  task automatic t_async_reset();
    shift_i = 1'b0; hold_i = 1'b0; par_i = 8'hC3;
    step();
    #2 rst_ni = 1'b0;
    #1;
    check("R1", q_o, '0);
    par_i = 8'hE7;
    repeat (3) step();
    check("R2", q_o, '0);
    #2 rst_ni = 1'b1;
    #1;
    check("R9", q_o, '0);
    step();
    check("R9", q_o, 8'hE7);
  endtask

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_shift();
    t_pattern(8'hB2);
    t_pattern(8'h4D);
    t_shift_ignores_hold();
    t_async_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule